// File: doc/BRIEF.md
# Programmable BCD Divide-by-N Counter

This block divides its clock by a modulus given as a two-digit BCD word. A decimal down counter runs from the programmed value N to zero. On the enabled edge after it reaches zero, it reloads the preset and inverts a divided output. That output is therefore a square wave with a period of 2(N+1) input clocks. A terminal flag marks the cycles in which the count is zero.

Three controls act on the next rising clock edge:
- A load control reloads the preset word without touching the output.
- A clear control reloads the counter and drives the output low.
- A set control reloads the counter and drives the output high.

A count enable freezes both the counter and the output. The load control still works while counting is frozen. A two-channel divider is two instances of this block.

Top module: `bcd_divn_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count becomes 00 and `q_out` becomes low. `term_out` is therefore high after reset.
- R2: `preset_word[3:0]` is the units digit and `preset_word[7:4]` is the tens digit. Each digit above 9 is loaded as 9, so preset 0xAF loads 99.
- R3: `term_out` is high exactly while the count is 00. An enabled edge taken at count 00, with no control active, reloads the preset and inverts `q_out`.
- R4: Each enabled edge above 00 decrements the count in BCD. The units digit wraps from 0 to 9 and borrows one from the tens digit. With preset N, `q_out` inverts once every N+1 enabled edges.
- R5: `clr` high loads the preset and forces `q_out` low. It overrides `set_hi`, `load_en` and `cnt_en`.
- R6: `set_hi` high with `clr` low loads the preset and forces `q_out` high. It overrides `load_en` and `cnt_en`.
- R7: `load_en` high with `clr` and `set_hi` low loads the preset and leaves `q_out` unchanged. This works whether `cnt_en` is high or low.
- R8: With `cnt_en` low and no control active, the count and `q_out` hold their values.
- R9: With preset 00 and `cnt_en` high, `q_out` inverts on every edge and `term_out` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count enable; low freezes count and output |
| preset_word | input | 8 | BCD modulus: tens digit in [7:4], units digit in [3:0] |
| load_en | input | 1 | Synchronous load of the preset word |
| clr | input | 1 | Synchronous reload with output forced low |
| set_hi | input | 1 | Synchronous reload with output forced high |
| q_out | output | 1 | Divided square-wave output |
| term_out | output | 1 | High while the count is 00 |

## Verification
Every registered effect appears one clock after the rising edge that takes the stimulus. This covers a decrement, a reload, an output inversion and the effect of a control. `term_out` follows the count with no further delay. The bench drives inputs on the falling edge and steps a behavioural decimal model on the rising edge. It compares `q_out` and `term_out` on the next falling edge, so each comparison sees the result of exactly one edge. The toggle-interval and clamp checks count edges between output events, and these counts follow the N+1 rule.

// File: rtl/bcd_div_pkg.sv
// Package: shared digit type, control-operation encoding and the digit
// clamp used by the divide-by-N counter. Assumes 4-bit BCD digits.
package bcd_div_pkg;

    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    // Operation chosen for the next clock edge, in priority order.
    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_COUNT    = 3'd1,
        OP_WRAP     = 3'd2,
        OP_LOAD     = 3'd3,
        OP_FORCE_LO = 3'd4,
        OP_FORCE_HI = 3'd5
    } div_op_t;

    // Limit a raw nibble to a legal decimal digit.
    function automatic bcd_digit_t clamp_digit(input bcd_digit_t raw);
        return (raw > DIGIT_MAX) ? DIGIT_MAX : raw;
    endfunction

endpackage

// File: rtl/bcd_preset_clamp.sv
// Module: sanitises a packed BCD preset word digit by digit. Any nibble
// above 9 becomes 9. Purely combinational; assumes digit 0 in the low bits.
module bcd_preset_clamp
    import bcd_div_pkg::*;
#(
    parameter int NUM_DIGITS = 2,
    localparam int WORD_W = NUM_DIGITS * DIGIT_W
) (
    input  logic [WORD_W-1:0] raw_word,
    output logic [WORD_W-1:0] clean_word
);

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        // Clamp one nibble of the preset.
        always_comb begin
            clean_word[g*DIGIT_W +: DIGIT_W] = clamp_digit(raw_word[g*DIGIT_W +: DIGIT_W]);
        end
    end

endmodule

// File: rtl/bcd_down_digit.sv
// Module: one decimal down-counting digit. It loads a value or steps down
// when dec_in is high, and wraps 0 to 9 with a borrow to the next digit.
// Assumes load_val is already a legal BCD digit.
module bcd_down_digit
    import bcd_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  bcd_digit_t load_val,
    input  logic       dec_in,
    output bcd_digit_t digit,
    output logic       is_zero,
    output logic       borrow_out
);

    // Digit state: reset, load, or BCD decrement with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit <= '0;
        end else if (load) begin
            digit <= load_val;
        end else if (dec_in) begin
            digit <= (digit == '0) ? DIGIT_MAX : digit - 1'b1;
        end
    end

    // Zero flag and borrow to the next digit up.
    always_comb begin
        is_zero    = (digit == '0);
        borrow_out = dec_in & is_zero;
    end

endmodule

// File: rtl/divn_ctrl.sv
// Module: picks the operation for the next edge, in this priority order:
// clear, set-high, load, then (when enabled) wrap at zero or count down.
// Combinational; assumes all inputs are synchronous to the counter clock.
module divn_ctrl
    import bcd_div_pkg::*;
(
    input  logic    cnt_en,
    input  logic    load_en,
    input  logic    clr,
    input  logic    set_hi,
    input  logic    all_zero,
    output div_op_t op,
    output logic    reload,
    output logic    step
);

    // Priority decode of the controls.
    always_comb begin
        if (clr)           op = OP_FORCE_LO;
        else if (set_hi)   op = OP_FORCE_HI;
        else if (load_en)  op = OP_LOAD;
        else if (!cnt_en)  op = OP_IDLE;
        else if (all_zero) op = OP_WRAP;
        else               op = OP_COUNT;
    end

    // Derived strobes for the digit chain.
    always_comb begin
        reload = (op == OP_FORCE_LO) || (op == OP_FORCE_HI) ||
                 (op == OP_LOAD)     || (op == OP_WRAP);
        step   = (op == OP_COUNT);
    end

endmodule

// File: rtl/divn_q_reg.sv
// Module: the divided output flop. It is forced low or high, or inverted
// on a wrap, and otherwise holds its value. Resets low.
module divn_q_reg
    import bcd_div_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  div_op_t op,
    output logic    q
);

    // Output state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            case (op)
                OP_FORCE_LO: q <= 1'b0;
                OP_FORCE_HI: q <= 1'b1;
                OP_WRAP:     q <= ~q;
                default:     q <= q;
            endcase
        end
    end

endmodule

// File: rtl/bcd_divn_counter.sv
// Module: top of the programmable BCD divide-by-N counter. It chains
// NUM_DIGITS decimal down digits and reloads them from the clamped preset
// at zero, where it also inverts q_out. Synchronous active-low reset.
module bcd_divn_counter
    import bcd_div_pkg::*;
#(
    parameter int NUM_DIGITS = 2,
    localparam int WORD_W = NUM_DIGITS * DIGIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [WORD_W-1:0] preset_word,
    input  logic              load_en,
    input  logic              clr,
    input  logic              set_hi,
    output logic              q_out,
    output logic              term_out
);

    logic [WORD_W-1:0]   preset_clean;
    logic [WORD_W-1:0]   cnt_val;
    logic [NUM_DIGITS-1:0] digit_zero;
    logic [NUM_DIGITS:0] borrow_chain;
    logic                all_zero;
    logic                reload;
    logic                step;
    logic                top_borrow;
    div_op_t             op;

    bcd_preset_clamp #(.NUM_DIGITS(NUM_DIGITS)) u_clamp (
        .raw_word   (preset_word),
        .clean_word (preset_clean)
    );

    divn_ctrl u_ctrl (
        .cnt_en   (cnt_en),
        .load_en  (load_en),
        .clr      (clr),
        .set_hi   (set_hi),
        .all_zero (all_zero),
        .op       (op),
        .reload   (reload),
        .step     (step)
    );

    // The lowest digit steps on every counting edge.
    always_comb begin
        borrow_chain[0] = step;
    end

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_cnt
        bcd_down_digit u_digit (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (reload),
            .load_val   (preset_clean[g*DIGIT_W +: DIGIT_W]),
            .dec_in     (borrow_chain[g]),
            .digit      (cnt_val[g*DIGIT_W +: DIGIT_W]),
            .is_zero    (digit_zero[g]),
            .borrow_out (borrow_chain[g+1])
        );
    end

    // Whole-count zero detect and the borrow out of the top digit.
    always_comb begin
        all_zero   = &digit_zero;
        top_borrow = borrow_chain[NUM_DIGITS];
    end

    divn_q_reg u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .q     (q_out)
    );

    // Terminal flag is high while the count is zero.
    always_comb begin
        term_out = all_zero;
    end

endmodule

// File: rtl/bcd_divn_counter_chk.sv
// Module: property checker for bcd_divn_counter, attached with bind.
// It observes the ports plus the count and the top-digit borrow.
module bcd_divn_counter_chk
    import bcd_div_pkg::*;
#(
    parameter int NUM_DIGITS = 2,
    localparam int WORD_W = NUM_DIGITS * DIGIT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic              load_en,
    input logic              clr,
    input logic              set_hi,
    input logic              q_out,
    input logic              term_out,
    input logic [WORD_W-1:0] cnt_val,
    input logic              top_borrow
);

    AST_CLR_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q_out); // R5

    AST_SET_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && set_hi) |=> q_out); // R6

    AST_WRAP_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (term_out && cnt_en && !clr && !set_hi && !load_en) |=> (q_out != $past(q_out))); // R3

    AST_COUNT_HOLDS_Q: assert property (@(posedge clk) disable iff (!rst_n)
        (!term_out && !clr && !set_hi) |=> $stable(q_out)); // R4

    AST_LOAD_KEEPS_Q: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !clr && !set_hi) |=> $stable(q_out)); // R7

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !clr && !set_hi && !load_en) |=> ($stable(q_out) && $stable(cnt_val))); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !top_borrow); // R4

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_rng
        AST_BCD_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_val[g*DIGIT_W +: DIGIT_W] <= DIGIT_MAX); // R2
    end

endmodule

bind bcd_divn_counter bcd_divn_counter_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .load_en    (load_en),
    .clr        (clr),
    .set_hi     (set_hi),
    .q_out      (q_out),
    .term_out   (term_out),
    .cnt_val    (cnt_val),
    .top_borrow (top_borrow)
);

// File: tb/tb_bcd_divn_counter.sv
// Bench: a decimal behavioural model, compared with the DUT on every clock.
module tb_bcd_divn_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [7:0] preset_word = 8'h00;
    logic       load_en = 1'b0;
    logic       clr = 1'b0;
    logic       set_hi = 1'b0;
    logic       q_out;
    logic       term_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string phase = "R1";

    int m_cnt = 0;
    bit m_q = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bcd_divn_counter dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .preset_word(preset_word),
        .load_en(load_en), .clr(clr), .set_hi(set_hi),
        .q_out(q_out), .term_out(term_out)
    );

    function automatic int preset_value(input logic [7:0] w);
        int tens = (w[7:4] > 9) ? 9 : int'(w[7:4]);
        int units = (w[3:0] > 9) ? 9 : int'(w[3:0]);
        return tens * 10 + units;
    endfunction

    // Behavioural reference: one update per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_q = 1'b0;
        end else if (clr) begin
            m_cnt = preset_value(preset_word); m_q = 1'b0;
        end else if (set_hi) begin
            m_cnt = preset_value(preset_word); m_q = 1'b1;
        end else if (load_en) begin
            m_cnt = preset_value(preset_word);
        end else if (cnt_en) begin
            if (m_cnt == 0) begin
                m_cnt = preset_value(preset_word); m_q = ~m_q;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Advance one edge, then compare on the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check(phase, q_out, m_q, "q_out");
        check(phase, term_out, (m_cnt == 0), "term_out");
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        int last_edge;
        int edges;
        int interval;
        logic prev_q;
        @(negedge clk);
        phase = "R1";
        run(3);
        check("R1", q_out, 1'b0, "reset q_out");
        check("R1", term_out, 1'b1, "reset term_out");
        rst_n = 1'b1;

        // R4 / R3: divide by preset 12 with a reload every 13 edges.
        phase = "R4";
        preset_word = 8'h12; load_en = 1'b1; step(); load_en = 1'b0;
        cnt_en = 1'b1;
        last_edge = -1; edges = 0; prev_q = q_out;
        for (int i = 1; i <= 60; i++) begin
            step();
            if (q_out !== prev_q) begin
                if (last_edge >= 0) begin
                    interval = i - last_edge;
                    check("R4", interval == 13, 1'b1, "toggle interval is 13");
                end
                last_edge = i; edges++;
            end
            prev_q = q_out;
        end
        check("R3", edges >= 4, 1'b1, "reload toggles seen");

        // R4: a units wrap across a tens borrow (20 -> 19).
        phase = "R4";
        preset_word = 8'h20; load_en = 1'b1; step(); load_en = 1'b0;
        run(25);

        // R9: preset 00 toggles every edge.
        phase = "R9";
        preset_word = 8'h00; load_en = 1'b1; step(); load_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            prev_q = q_out;
            step();
            check("R9", q_out, ~prev_q, "toggle each edge");
            check("R9", term_out, 1'b1, "term stays high");
        end

        // R2: preset 0xAF clamps to 99, so zero arrives after 99 edges.
        phase = "R2";
        preset_word = 8'hAF; load_en = 1'b1; step(); load_en = 1'b0;
        edges = 0;
        for (int i = 0; i < 120 && term_out !== 1'b1; i++) begin
            step(); edges++;
        end
        check("R2", edges == 99, 1'b1, "clamped count length 99");
        preset_word = 8'h3C; load_en = 1'b1; step(); load_en = 1'b0;
        run(45);

        // R8 and R7: freeze, then load while frozen.
        phase = "R8";
        preset_word = 8'h07; load_en = 1'b1; step(); load_en = 1'b0;
        run(3);
        cnt_en = 1'b0;
        prev_q = q_out;
        run(10);
        check("R8", q_out, prev_q, "frozen q_out");
        phase = "R7";
        preset_word = 8'h00; load_en = 1'b1; step(); load_en = 1'b0;
        check("R7", term_out, 1'b1, "load while frozen");
        check("R7", q_out, prev_q, "load keeps q_out");
        run(3);
        cnt_en = 1'b1;
        preset_word = 8'h05;

        // R5 and R6: forced levels and their priority.
        phase = "R6";
        set_hi = 1'b1; load_en = 1'b1; step(); set_hi = 1'b0; load_en = 1'b0;
        check("R6", q_out, 1'b1, "set_hi over load_en");
        run(4);
        phase = "R5";
        clr = 1'b1; set_hi = 1'b1; cnt_en = 1'b0; step(); clr = 1'b0; set_hi = 1'b0;
        check("R5", q_out, 1'b0, "clr over set_hi");
        cnt_en = 1'b1;
        run(20);
        phase = "R6";
        set_hi = 1'b1; cnt_en = 1'b0; step(); set_hi = 1'b0;
        check("R6", q_out, 1'b1, "set_hi while frozen");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule